// File: doc/BRIEF.md
# Predicated Vector Scatter-Store Sequencer

This block turns one vector scatter-store operation into a stream of single-word memory writes. On a start pulse it captures a 64-bit scalar base, a flat vector of index values, a flat vector of source data, a byte-granular predicate and a set of mode bits. For every element whose predicate bit is set, it forms an address from the base and the element's index and issues one 32-bit write on a valid/ready port. Elements are visited from the lowest to the highest.

The mode bits select the element width (32 or 64 bits) and the index width (32 or 64 bits). They also choose sign or zero extension of a 32-bit index and a left shift of the index by 0 or 2. When the base is flagged as the stack pointer, the block checks that the base is 16-byte aligned. A misaligned base raises a fault and cancels every write of the operation. The busy and done outputs let a sequencer upstream know when the operation has finished.

Top module: `scatter_store_seq`

## Requirements
- R1: The write address of an element is base + (offset << s) modulo 2^64, where s is 2 when `scale_by4` is 1 and 0 otherwise.
- R2: When `elem_is64` is 0 or `offs_is64` is 0, the offset is taken from the low 32 bits of the index element. It is zero-extended when `offs_signed` is 0 and sign-extended when `offs_signed` is 1. With 32-bit elements, `offs_is64` has no effect.
- R3: When both `elem_is64` and `offs_is64` are 1, the offset is the full 64-bit index element, taken as unsigned.
- R4: With `elem_is64`=0 there are VLEN/32 elements, and element e occupies bits [32e+31:32e] of the index and source vectors. With `elem_is64`=1 there are VLEN/64 elements at bits [64e+63:64e]. The write data is the low 32 bits of the source element, and `wr_strb` is 4'hF.
- R5: Element e is active when predicate bit 4e (32-bit elements) or 8e (64-bit elements) is 1. An inactive element causes no write. Predicate bits at other positions are ignored.
- R6: Active elements are written in ascending element order.
- R7: A presented write keeps `wr_valid` high, and its address and data stable, until `wr_ready` is 1.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last active write is accepted. In that same cycle `done` is high, for exactly one cycle. A start with no active element (or with a fault) gives `done` in the cycle after start, and `busy` stays low.
- R9: When `base_is_sp` is 1 and `base[3:0]` is not 0, a fault is raised if at least one element is active or `sp_check_empty` is 1. A fault raises `sp_fault` together with `done` and suppresses all writes.
- R10: A start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; operands are captured on it |
| base | input | 64 | Scalar base address |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| sp_check_empty | input | 1 | Check alignment even when no element is active |
| idx_vec | input | VLEN | Flat index vector |
| src_vec | input | VLEN | Flat source data vector |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| elem_is64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| offs_is64 | input | 1 | 1: 64-bit unsigned offset (64-bit elements only) |
| offs_signed | input | 1 | Sign-extend a 32-bit offset |
| scale_by4 | input | 1 | Shift the offset left by 2 |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted by memory |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Byte strobe, always all ones |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_fault | output | 1 | Stack-pointer alignment fault, with done |

## Verification
A corrupted pending-element mask shows at the write port within one accepted write: an extra write, a missing write or an out-of-order write. The scoreboard catches it when it pops that write, or when it finds the queue not empty at done. A wrong extension or shift choice gives a wrong address on the first active element. A stuck busy/done state shows as a missing done within a few cycles of the last write, and a late or early done is caught on the exact cycle. A fault decision that goes wrong shows either as writes during a faulting operation or as a missing `sp_fault` in the cycle after start.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef struct packed {
    logic elem64;
    logic offs64;
    logic sx;
    logic sc2;
  } ss_mode_t;

  // Offset after width selection, extension and scaling
  function automatic logic [63:0] ss_offset(input logic [63:0] raw, input ss_mode_t m);
    logic [63:0] ext;
    if (m.elem64 && m.offs64) ext = raw;
    else if (m.sx)            ext = {{32{raw[31]}}, raw[31:0]};
    else                      ext = {32'd0, raw[31:0]};
    return m.sc2 ? (ext << 2) : ext;
  endfunction

  // Element address, wraps modulo 2^64
  function automatic logic [63:0] ss_addr(input logic [63:0] b, input logic [63:0] raw,
                                          input ss_mode_t m);
    return b + ss_offset(raw, m);
  endfunction
endpackage

// File: rtl/ss_active_mask.sv
module ss_active_mask #(
  parameter int VLEN = 256,
  localparam int PW  = VLEN / 8,
  localparam int N32 = VLEN / 32,
  localparam int N64 = VLEN / 64
) (
  input  logic [PW-1:0]  pred,
  input  logic           elem64,
  output logic [N32-1:0] act
);
  for (genvar e = 0; e < N32; e++) begin : g_el
    if (e < N64) begin : g_both
      assign act[e] = elem64 ? pred[e*8] : pred[e*4];
    end else begin : g_narrow
      assign act[e] = elem64 ? 1'b0 : pred[e*4];
    end
  end
endmodule

// File: rtl/ss_pick_first.sv
module ss_pick_first #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any    = |req;
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/ss_elem_fetch.sv
module ss_elem_fetch #(
  parameter int VLEN = 256,
  localparam int N32 = VLEN / 32,
  localparam int IW  = (N32 > 1) ? $clog2(N32) : 1,
  localparam int SHW = $clog2(VLEN) + 1
) (
  input  logic [VLEN-1:0] idx_vec,
  input  logic [VLEN-1:0] src_vec,
  input  logic [IW-1:0]   sel,
  input  logic            elem64,
  output logic [63:0]     raw_idx,
  output logic [31:0]     word
);
  logic [SHW-1:0]  shamt;
  logic [VLEN-1:0] idx_sh, src_sh;

  always_comb begin
    shamt   = SHW'(sel) << (elem64 ? 6 : 5);
    idx_sh  = idx_vec >> shamt;
    src_sh  = src_vec >> shamt;
    raw_idx = elem64 ? idx_sh[63:0] : {32'd0, idx_sh[31:0]};
    word    = src_sh[31:0];
  end
endmodule

// File: rtl/scatter_store_seq.sv
module scatter_store_seq
  import ss_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW  = VLEN / 8,
  localparam int N32 = VLEN / 32,
  localparam int IW  = (N32 > 1) ? $clog2(N32) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [63:0]     base,
  input  logic            base_is_sp,
  input  logic            sp_check_empty,
  input  logic [VLEN-1:0] idx_vec,
  input  logic [VLEN-1:0] src_vec,
  input  logic [PW-1:0]   pred,
  input  logic            elem_is64,
  input  logic            offs_is64,
  input  logic            offs_signed,
  input  logic            scale_by4,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [63:0]     wr_addr,
  output logic [31:0]     wr_data,
  output logic [3:0]      wr_strb,
  output logic            busy,
  output logic            done,
  output logic            sp_fault
);
  logic [N32-1:0]  act_in, pend_q, pick_oh, pend_next;
  logic [IW-1:0]   pick_idx;
  logic            pick_any, any_act_in;
  logic [63:0]     base_q, raw_idx;
  logic [VLEN-1:0] idx_q, src_q;
  ss_mode_t        mode_q;
  logic            busy_q, done_q, fault_q;
  logic            start_take, fault_now, accept, last_elem;
  logic [31:0]     word;

  ss_active_mask #(.VLEN(VLEN)) u_mask (.pred(pred), .elem64(elem_is64), .act(act_in));

  ss_pick_first #(.N(N32)) u_pick (.req(pend_q), .idx(pick_idx), .onehot(pick_oh), .any(pick_any));

  ss_elem_fetch #(.VLEN(VLEN)) u_fetch (
    .idx_vec(idx_q), .src_vec(src_q), .sel(pick_idx), .elem64(mode_q.elem64),
    .raw_idx(raw_idx), .word(word)
  );

  // Named events
  assign any_act_in = |act_in;
  assign start_take = start && !busy_q;
  assign fault_now  = base_is_sp && (base[3:0] != 4'd0) && (any_act_in || sp_check_empty);
  assign accept     = wr_valid && wr_ready;
  assign pend_next  = pend_q & ~pick_oh;
  assign last_elem  = (pend_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pend_q  <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      src_q   <= '0;
      mode_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (start_take) begin
        base_q <= base;
        idx_q  <= idx_vec;
        src_q  <= src_vec;
        mode_q <= '{elem64: elem_is64, offs64: offs_is64, sx: offs_signed, sc2: scale_by4};
        if (fault_now || !any_act_in) begin
          done_q  <= 1'b1;
          fault_q <= fault_now;
        end else begin
          busy_q <= 1'b1;
          pend_q <= act_in;
        end
      end else if (accept) begin
        pend_q <= pend_next;
        if (last_elem) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign wr_valid = busy_q;
  assign wr_addr  = ss_addr(base_q, raw_idx, mode_q);
  assign wr_data  = word;
  assign wr_strb  = 4'hF;
  assign busy     = busy_q;
  assign done     = done_q;
  assign sp_fault = fault_q;

  // R7: stalled write holds
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R8: done is a single-cycle pulse and implies idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: fault comes with done and no write
  a_r9_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sp_fault |-> done && !wr_valid);
  // R5: the presented element is one pending element
  a_r5_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $onehot(pick_oh) && ((pick_oh & ~pend_q) == '0));
  // R6: next element index is strictly higher
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_elem |=> pick_idx > $past(pick_idx));
  // R10: start while busy leaves pending work alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !accept |=> $stable(pend_q));
endmodule

// File: tb/tb_scatter_store_seq.sv
`timescale 1ns/1ps
module tb_scatter_store_seq;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0]     base = '0;
  logic            base_is_sp = 1'b0, sp_check_empty = 1'b0;
  logic [VLEN-1:0] idx_vec = '0, src_vec = '0;
  logic [PW-1:0]   pred = '0;
  logic            elem_is64 = 1'b0, offs_is64 = 1'b0, offs_signed = 1'b0, scale_by4 = 1'b0;
  logic            wr_valid, wr_ready = 1'b1;
  logic [63:0]     wr_addr;
  logic [31:0]     wr_data;
  logic [3:0]      wr_strb;
  logic            busy, done, sp_fault;

  int tests = 0, fails = 0, cyc = 0, rdy_mode = 0;
  logic [63:0] exp_addr[$];
  logic [31:0] exp_data[$];
  logic        prev_stall = 1'b0;
  logic [63:0] prev_addr = '0;

  scatter_store_seq #(.VLEN(VLEN)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
    end
  endtask

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    cyc++;
    #1;
    wr_ready <= (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 0);
  end

  // watchdog
  always @(posedge clk) if (cyc > 100000) begin
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // monitor: compare accepted writes against the scoreboard
  always @(negedge clk) if (rst_n) begin
    if (prev_stall) chk(wr_valid && wr_addr == prev_addr, "R7", "stalled write changed", wr_addr, prev_addr);
    if (wr_valid) begin
      if (wr_strb != 4'hF) chk(0, "R4", "strobe", 64'(wr_strb), 64'hF);
      if (wr_ready) begin
        if (exp_addr.size() == 0) chk(0, "R5/R9", "unexpected write", wr_addr, 64'd0);
        else begin
          logic [63:0] ea; logic [31:0] ed;
          ea = exp_addr.pop_front(); ed = exp_data.pop_front();
          chk(wr_addr == ea, "R1/R6", "address", wr_addr, ea);
          chk(wr_data == ed, "R4", "data", 64'(wr_data), 64'(ed));
        end
      end
    end
    prev_stall = wr_valid && !wr_ready;
    prev_addr  = wr_addr;
  end

  // independent model of one operation; returns number of writes expected
  function automatic int model(input logic [63:0] b, input bit sp, input bit pol,
                               input logic [VLEN-1:0] iv, input logic [VLEN-1:0] sv,
                               input logic [PW-1:0] p, input bit e64, input bit o64,
                               input bit sx, input bit sc, output bit flt);
    int n, step, cnt;
    logic [63:0] off;
    n = e64 ? VLEN/64 : VLEN/32;
    step = e64 ? 8 : 4;
    cnt = 0;
    for (int e = 0; e < n; e++) if (p[e*step]) cnt++;
    flt = sp && (b % 16 != 0) && (cnt > 0 || pol);
    if (flt) return 0;
    for (int e = 0; e < n; e++) begin
      if (!p[e*step]) continue;
      if (e64 && o64) off = iv[e*64 +: 64];
      else if (sx)    off = 64'($signed(iv[e*(e64?64:32) +: 32]));
      else            off = 64'(iv[e*(e64?64:32) +: 32]);
      if (sc) off = off * 4;
      exp_addr.push_back(b + off);
      exp_data.push_back(sv[e*(e64?64:32) +: 32]);
    end
    return cnt;
  endfunction

  task automatic run_op(input string tag, input logic [63:0] b, input bit sp, input bit pol,
                        input logic [VLEN-1:0] iv, input logic [VLEN-1:0] sv,
                        input logic [PW-1:0] p, input bit e64, input bit o64,
                        input bit sx, input bit sc, input int rm, input bit poke);
    int cnt, wait_c;
    bit flt;
    cnt = model(b, sp, pol, iv, sv, p, e64, o64, sx, sc, flt);
    rdy_mode = rm;
    @(negedge clk);
    base = b; base_is_sp = sp; sp_check_empty = pol; idx_vec = iv; src_vec = sv; pred = p;
    elem_is64 = e64; offs_is64 = o64; offs_signed = sx; scale_by4 = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flt || cnt == 0) begin
      chk(done && !busy, "R8", {tag, " immediate done"}, {62'd0, done, busy}, 64'd2);
      chk(sp_fault == flt, "R9", {tag, " fault flag"}, 64'(sp_fault), 64'(flt));
    end else begin
      chk(busy && !done, "R8", {tag, " busy after start"}, {62'd0, done, busy}, 64'd1);
    end
    if (poke && busy) begin
      // R10: a second start with other operands must change nothing
      idx_vec = ~iv; base = b + 64'h1000; pred = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_c = 0;
    while (!done && wait_c < 1000) begin @(negedge clk); wait_c++; end
    chk(done && !busy, "R8", {tag, " done seen, idle"}, {62'd0, done, busy}, 64'd2);
    chk(exp_addr.size() == 0, "R5", {tag, " all writes seen"}, 64'(exp_addr.size()), 64'd0);
    if (!flt) chk(!sp_fault, "R9", {tag, " no fault"}, 64'(sp_fault), 64'd0);
    @(negedge clk);
    chk(!done, "R8", {tag, " done one cycle"}, 64'(done), 64'd0);
    exp_addr.delete(); exp_data.delete();
  endtask

  initial begin
    logic [VLEN-1:0] iv, sv;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !done && !sp_fault, "R8", "reset state",
        {60'd0, wr_valid, busy, done, sp_fault}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < VLEN/32; i++) begin
      iv[i*32 +: 32] = 32'h10 * i + 32'h8000_0000 * (i % 2);
      sv[i*32 +: 32] = 32'hA000_0000 + i;
    end
    // R2: 32-bit zero extension, no scale, all active
    run_op("R2 zext", 64'h1000, 0, 0, iv, sv, '1, 0, 0, 0, 0, 0, 0);
    // R2: sign extension, scale by 4, sparse predicate, stalls, start while busy (R10)
    run_op("R2 sext R10", 64'h2000_0000, 0, 0, iv, sv, 32'h1111_0101, 0, 0, 1, 1, 1, 1);
    // R2: offs_is64 ignored for 32-bit elements
    run_op("R2 o64 ignored", 64'h40, 0, 0, iv, sv, 32'h0101_1010, 0, 1, 0, 1, 0, 0);
    // R3: 64-bit unsigned offsets with wrap (R1), noise predicate bits (R5)
    for (int i = 0; i < VLEN/64; i++) begin
      iv[i*64 +: 64] = 64'hF000_0000_0000_0000 + 64'h123 * i;
      sv[i*64 +: 64] = {32'hDEAD_0000 + i, 32'h5000_0000 + i};
    end
    run_op("R3 off64", 64'h1000_0000_0000_0000, 0, 0, iv, sv, 32'h0E0F_01F1, 1, 1, 0, 1, 1, 0);
    // R4: 64-bit elements, 32-bit sign-extended offset ignores index upper half
    run_op("R4 e64 sext", 64'hFFFF_FFFF_FFFF_FF00, 0, 0, iv, sv, 32'h0101_0101, 1, 0, 1, 0, 0, 0);
    // R8: no active element
    run_op("R8 empty", 64'h0, 0, 0, iv, sv, 32'hEEEE_EEEE, 0, 0, 0, 0, 0, 0);
    // R9: misaligned SP with active elements
    run_op("R9 fault", 64'h1008, 1, 0, iv, sv, '1, 0, 0, 0, 0, 0, 0);
    // R9: misaligned SP, nothing active, policy on / off
    run_op("R9 empty pol1", 64'h1004, 1, 1, iv, sv, '0, 0, 0, 0, 0, 0, 0);
    run_op("R9 empty pol0", 64'h1004, 1, 0, iv, sv, '0, 0, 0, 0, 0, 0, 0);
    // R9: aligned SP writes normally
    run_op("R9 aligned", 64'h7FF0, 1, 1, iv, sv, 32'h0000_1101, 0, 0, 0, 1, 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule